// File: doc/BRIEF.md
# Dock Loop Counter, Flag and Predicate Unit

This block keeps the iteration and condition state of one programmable dock. It holds an outer loop counter, an inner loop counter (which can also hold an "infinity" value), two general-purpose flags A and B, a control flag C and a done flag D. Each cycle it may receive one decoded operation together with a 3-bit predicate. It evaluates the predicate against the current flags. A passing operation applies its counter or flag update. A failing operation is ignored and leaves all state as it was.

A torpedo strike is signalled on its own strobe. It overrides any operation presented in the same cycle. The dock sequencer reads back the counters and flags from the outputs, together with a registered execute decision for each operation. From these it decides how often a move repeats and whether a loop has finished.

All outputs are registered. An operation presented in cycle t is visible on the outputs after the clock edge that ends cycle t.

Top module: `dock_loop_flag_unit`

## Requirements
- R1: After a synchronous active-high reset, the unit holds the following values: inner count 1, infinity indication 0, outer count 0, D=1, A=B=C=0, execute decision 0 and error indication 0.
- R2: An operation is present when op_code is nonzero. The predicate decides whether it executes:
  - 000 executes when D=0 and A=0.
  - 001 executes when D=0 and A=1.
  - 010 executes when D=0 and B=0.
  - 011 executes when D=0 and B=1.
  - 101 executes when D=1.
  - 110 executes when D=0.
  - 111 always executes.
  exec_ok is 1 in the cycle after an executed operation and 0 otherwise. A skipped operation changes no counter or flag.
- R3: Predicate 100 never executes. The first operation that carries it sets pred_err, and pred_err stays set until reset.
- R4: op_code 1 loads the outer counter from imm[5:0]. op_code 2 loads it from dl_val[5:0]. After either load, D is 1 if the loaded value is zero and 0 otherwise.
- R5: op_code 3 decrements the outer counter. At zero the counter stays at 0. D becomes 1 when the result is zero; otherwise D is unchanged.
- R6: op_code 4 loads the inner counter from imm[5:0]. op_code 6 loads it from dl_val[5:0]. Both loads clear the infinity indication. op_code 5 sets the infinity indication.
- R7: op_code 8 (move) sets the inner counter to 1 and clears the infinity indication. A move whose inner count is 0 or infinity is treated the same way.
- R8: On an executed move, C is updated by the first rule that applies:
  - If dock_is_out=1 and mv_dc=1, C takes ship_c.
  - Otherwise, if mv_ti=1, or mv_di=1 with dock_is_out=0, C takes sig_bit.
  - Otherwise C keeps its value.
- R9: op_code 7 rebuilds A from the mask imm[5:0] and B from the mask imm[11:6]. In each mask, bit 5 selects A, bit 4 not-A, bit 3 B, bit 2 not-B, bit 1 C and bit 0 not-C. The selected old values are ORed together, so an all-zero mask gives 0.
- R10: A torpedo sets the inner counter to 1, clears the infinity indication and sets D. Any operation presented in the same cycle is discarded, and exec_ok stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Decoded operation, 0 = none |
| op_pred | input | 3 | Predicate code of the operation |
| imm | input | 12 | Immediate: counter value or two flag masks |
| dl_val | input | 6 | Low bits of the data latch |
| mv_dc | input | 1 | Move requests data capture |
| mv_ti | input | 1 | Move requests token input |
| mv_di | input | 1 | Move requests data input |
| dock_is_out | input | 1 | Dock is an output dock |
| ship_c | input | 1 | Control bit from the ship |
| sig_bit | input | 1 | Signal bit of the inbound packet |
| torpedo | input | 1 | Torpedo strike strobe |
| exec_ok | output | 1 | Previous operation executed |
| ilc_cnt | output | 6 | Inner loop count |
| ilc_inf | output | 1 | Inner count is infinity |
| olc_cnt | output | 6 | Outer loop count |
| flag_a | output | 1 | Flag A |
| flag_b | output | 1 | Flag B |
| flag_c | output | 1 | Control flag C |
| flag_d | output | 1 | Done flag D |
| pred_err | output | 1 | Sticky unused-predicate error |

## Verification
The hardest situation to reach is D set while the outer counter is nonzero. Only a torpedo can produce it, and operations predicated on D=0 then become blocked. The stimulus builds this state directly: it loads the outer counter with a nonzero value and then fires a torpedo. It then issues decrements under predicates 101 and 110, so that both the skip path and the "D unchanged" path are exercised. Long random runs with rare torpedoes follow, covering move, flag-mask and zero-load cases. A behavioural model compares every output on every cycle.

// File: rtl/dock_ctl_pkg.sv
package dock_ctl_pkg;
  localparam int FMASK_W = 6;

  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_OLC_IMM = 4'd1,
    OP_OLC_DL  = 4'd2,
    OP_OLC_DEC = 4'd3,
    OP_ILC_IMM = 4'd4,
    OP_ILC_INF = 4'd5,
    OP_ILC_DL  = 4'd6,
    OP_FLAGS   = 4'd7,
    OP_MOVE    = 4'd8
  } dock_op_e;

  // OR of the old flag terms selected by the mask
  function automatic logic mask_or(input logic [FMASK_W-1:0] m,
                                   input logic a, input logic b, input logic c);
    return |(m & {a, ~a, b, ~b, c, ~c});
  endfunction
endpackage

// File: rtl/dock_pred_eval.sv
module dock_pred_eval (
  input  logic [2:0] pred,
  input  logic       fa,
  input  logic       fb,
  input  logic       fd,
  output logic       pass,
  output logic       bad_code
);
  always_comb begin
    bad_code = 1'b0;
    case (pred)
      3'b000:  pass = !fd && !fa;
      3'b001:  pass = !fd && fa;
      3'b010:  pass = !fd && !fb;
      3'b011:  pass = !fd && fb;
      3'b100: begin
        pass     = 1'b0;
        bad_code = 1'b1;
      end
      3'b101:  pass = fd;
      3'b110:  pass = !fd;
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/dock_loop_ctr.sv
module dock_loop_ctr #(
  parameter int ILC_W = 6,
  parameter int OLC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             torpedo,
  input  logic             ld_olc_imm,
  input  logic             ld_olc_dl,
  input  logic             dec_olc,
  input  logic             ld_ilc_imm,
  input  logic             ld_ilc_inf,
  input  logic             ld_ilc_dl,
  input  logic             mv_fire,
  input  logic [OLC_W-1:0] olc_imm,
  input  logic [OLC_W-1:0] olc_dl,
  input  logic [ILC_W-1:0] ilc_imm,
  input  logic [ILC_W-1:0] ilc_dl,
  output logic [ILC_W-1:0] ilc_q,
  output logic             inf_q,
  output logic [OLC_W-1:0] olc_q,
  output logic             done_q
);
  localparam logic [ILC_W-1:0] ILC_ONE  = ILC_W'(1);
  localparam logic [OLC_W-1:0] OLC_ZERO = '0;

  logic [ILC_W-1:0] ilc_d;
  logic             inf_d;
  logic [OLC_W-1:0] olc_d;
  logic             done_d;

  always_comb begin
    ilc_d  = ilc_q;
    inf_d  = inf_q;
    olc_d  = olc_q;
    done_d = done_q;
    if (torpedo) begin
      ilc_d  = ILC_ONE;
      inf_d  = 1'b0;
      done_d = 1'b1;
    end else begin
      if (ld_olc_imm) begin
        olc_d  = olc_imm;
        done_d = (olc_imm == OLC_ZERO);
      end else if (ld_olc_dl) begin
        olc_d  = olc_dl;
        done_d = (olc_dl == OLC_ZERO);
      end else if (dec_olc) begin
        olc_d = (olc_q == OLC_ZERO) ? OLC_ZERO : olc_q - OLC_W'(1);
        if (olc_q <= OLC_W'(1)) done_d = 1'b1;
      end
      if (ld_ilc_imm) begin
        ilc_d = ilc_imm;
        inf_d = 1'b0;
      end else if (ld_ilc_dl) begin
        ilc_d = ilc_dl;
        inf_d = 1'b0;
      end else if (ld_ilc_inf) begin
        inf_d = 1'b1;
      end else if (mv_fire) begin
        ilc_d = ILC_ONE;
        inf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ilc_q  <= ILC_ONE;
      inf_q  <= 1'b0;
      olc_q  <= OLC_ZERO;
      done_q <= 1'b1;
    end else begin
      ilc_q  <= ilc_d;
      inf_q  <= inf_d;
      olc_q  <= olc_d;
      done_q <= done_d;
    end
  end

  p_torp_r10: assert property (@(posedge clk) disable iff (rst)
    torpedo |=> (done_q && ilc_q == ILC_ONE && !inf_q));
  p_dec_sat_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_olc && !torpedo && olc_q == OLC_ZERO) |=> (olc_q == OLC_ZERO && done_q));
  p_olc_done_r4: assert property (@(posedge clk) disable iff (rst)
    ((ld_olc_imm || ld_olc_dl) && !torpedo) |=> (done_q == (olc_q == OLC_ZERO)));
  p_move_r7: assert property (@(posedge clk) disable iff (rst)
    (mv_fire && !torpedo) |=> (ilc_q == ILC_ONE && !inf_q));
  p_inf_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_ilc_inf && !torpedo) |=> inf_q);
endmodule

// File: rtl/dock_flag_reg.sv
module dock_flag_reg
  import dock_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               set_flags,
  input  logic [FMASK_W-1:0] mask_a,
  input  logic [FMASK_W-1:0] mask_b,
  input  logic               mv_fire,
  input  logic               mv_dc,
  input  logic               mv_ti,
  input  logic               mv_di,
  input  logic               is_out,
  input  logic               ship_c,
  input  logic               sig_bit,
  output logic               a_q,
  output logic               b_q,
  output logic               c_q
);
  logic c_d;

  always_comb begin
    c_d = c_q;
    if (mv_fire) begin
      if (is_out && mv_dc)            c_d = ship_c;
      else if (mv_ti || (mv_di && !is_out)) c_d = sig_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      if (set_flags) begin
        a_q <= mask_or(mask_a, a_q, b_q, c_q);
        b_q <= mask_or(mask_b, a_q, b_q, c_q);
      end
      c_q <= c_d;
    end
  end

  p_zero_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (set_flags && mask_a == '0) |=> !a_q);
  p_one_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (set_flags && mask_b[3] && mask_b[2]) |=> b_q);
  p_c_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !mv_fire |=> $stable(c_q));
  p_c_ship_r8: assert property (@(posedge clk) disable iff (rst)
    (mv_fire && is_out && mv_dc) |=> (c_q == $past(ship_c)));
endmodule

// File: rtl/dock_loop_flag_unit.sv
module dock_loop_flag_unit
  import dock_ctl_pkg::*;
#(
  parameter int ILC_W = 6,
  parameter int OLC_W = 6,
  parameter int DL_W  = (ILC_W > OLC_W) ? ILC_W : OLC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         op_code,
  input  logic [2:0]         op_pred,
  input  logic [2*FMASK_W-1:0] imm,
  input  logic [DL_W-1:0]    dl_val,
  input  logic               mv_dc,
  input  logic               mv_ti,
  input  logic               mv_di,
  input  logic               dock_is_out,
  input  logic               ship_c,
  input  logic               sig_bit,
  input  logic               torpedo,
  output logic               exec_ok,
  output logic [ILC_W-1:0]   ilc_cnt,
  output logic               ilc_inf,
  output logic [OLC_W-1:0]   olc_cnt,
  output logic               flag_a,
  output logic               flag_b,
  output logic               flag_c,
  output logic               flag_d,
  output logic               pred_err
);
  dock_op_e op;
  logic op_valid, pass, bad_code, fire;

  assign op       = dock_op_e'(op_code);
  assign op_valid = (op_code != 4'd0);
  assign fire     = op_valid && pass && !torpedo;

  dock_pred_eval u_pred (
    .pred(op_pred), .fa(flag_a), .fb(flag_b), .fd(flag_d),
    .pass(pass), .bad_code(bad_code)
  );

  dock_loop_ctr #(.ILC_W(ILC_W), .OLC_W(OLC_W)) u_ctr (
    .clk(clk), .rst(rst), .torpedo(torpedo),
    .ld_olc_imm(fire && op == OP_OLC_IMM),
    .ld_olc_dl (fire && op == OP_OLC_DL),
    .dec_olc   (fire && op == OP_OLC_DEC),
    .ld_ilc_imm(fire && op == OP_ILC_IMM),
    .ld_ilc_inf(fire && op == OP_ILC_INF),
    .ld_ilc_dl (fire && op == OP_ILC_DL),
    .mv_fire   (fire && op == OP_MOVE),
    .olc_imm(imm[OLC_W-1:0]), .olc_dl(dl_val[OLC_W-1:0]),
    .ilc_imm(imm[ILC_W-1:0]), .ilc_dl(dl_val[ILC_W-1:0]),
    .ilc_q(ilc_cnt), .inf_q(ilc_inf), .olc_q(olc_cnt), .done_q(flag_d)
  );

  dock_flag_reg u_flags (
    .clk(clk), .rst(rst),
    .set_flags(fire && op == OP_FLAGS),
    .mask_a(imm[FMASK_W-1:0]), .mask_b(imm[2*FMASK_W-1:FMASK_W]),
    .mv_fire(fire && op == OP_MOVE),
    .mv_dc(mv_dc), .mv_ti(mv_ti), .mv_di(mv_di), .is_out(dock_is_out),
    .ship_c(ship_c), .sig_bit(sig_bit),
    .a_q(flag_a), .b_q(flag_b), .c_q(flag_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_ok  <= 1'b0;
      pred_err <= 1'b0;
    end else begin
      exec_ok <= fire;
      if (op_valid && bad_code) pred_err <= 1'b1;
    end
  end

  p_code4_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_pred == 3'b100) |=> (!exec_ok && pred_err));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    pred_err |=> pred_err);
  p_skip_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_pred == 3'b101 && !flag_d && !torpedo)
      |=> (!exec_ok && $stable(olc_cnt) && $stable(ilc_cnt) && $stable(flag_a)));
  p_torp_noexec_r10: assert property (@(posedge clk) disable iff (rst)
    torpedo |=> !exec_ok);
endmodule

// File: tb/test_dock_loop_flag_unit.sv
`timescale 1ns/1ps
module test_dock_loop_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] op_code = '0;
  logic [2:0] op_pred = '0;
  logic [11:0] imm = '0;
  logic [5:0] dl_val = '0;
  logic mv_dc = 0, mv_ti = 0, mv_di = 0, dock_is_out = 0, ship_c = 0, sig_bit = 0, torpedo = 0;
  logic exec_ok, ilc_inf, flag_a, flag_b, flag_c, flag_d, pred_err;
  logic [5:0] ilc_cnt, olc_cnt;

  always #2 clk = ~clk;

  dock_loop_flag_unit i_dock_loop_flag_unit (
    .clk(clk), .rst(rst), .op_code(op_code), .op_pred(op_pred), .imm(imm),
    .dl_val(dl_val), .mv_dc(mv_dc), .mv_ti(mv_ti), .mv_di(mv_di),
    .dock_is_out(dock_is_out), .ship_c(ship_c), .sig_bit(sig_bit),
    .torpedo(torpedo), .exec_ok(exec_ok), .ilc_cnt(ilc_cnt), .ilc_inf(ilc_inf),
    .olc_cnt(olc_cnt), .flag_a(flag_a), .flag_b(flag_b), .flag_c(flag_c),
    .flag_d(flag_d), .pred_err(pred_err)
  );

  int checks = 0, errors = 0;
  bit done_run = 0;
  // reference model state
  int m_ilc = 1, m_olc = 0;
  bit m_inf = 0, m_a = 0, m_b = 0, m_c = 0, m_d = 1, m_exec = 0, m_err = 0;

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit pred_ok(input bit [2:0] p, input bit a, input bit b, input bit d);
    case (p)
      3'd0: return !d && !a;
      3'd1: return !d && a;
      3'd2: return !d && !b;
      3'd3: return !d && b;
      3'd4: return 0;
      3'd5: return d;
      3'd6: return !d;
      default: return 1;
    endcase
  endfunction

  function automatic bit mor(input bit [5:0] m, input bit a, input bit b, input bit c);
    return (m[5] & a) | (m[4] & !a) | (m[3] & b) | (m[2] & !b) | (m[1] & c) | (m[0] & !c);
  endfunction

  task automatic compare_all();
    chk("R2", "exec_ok", exec_ok, m_exec);
    chk("R6", "ilc_cnt", ilc_cnt, m_ilc);
    chk("R6", "ilc_inf", ilc_inf, m_inf);
    chk("R4", "olc_cnt", olc_cnt, m_olc);
    chk("R4", "flag_d", flag_d, m_d);
    chk("R9", "flag_a", flag_a, m_a);
    chk("R9", "flag_b", flag_b, m_b);
    chk("R8", "flag_c", flag_c, m_c);
    chk("R3", "pred_err", pred_err, m_err);
  endtask

  // apply current inputs for one clock, advance model, compare at negedge
  task automatic step();
    bit na, nb;
    m_exec = 0;
    if (torpedo) begin
      m_ilc = 1; m_inf = 0; m_d = 1;
      if (op_code != 0 && op_pred == 3'd4) m_err = 1;
    end else if (op_code != 0) begin
      if (op_pred == 3'd4) m_err = 1;
      if (pred_ok(op_pred, m_a, m_b, m_d)) begin
        m_exec = 1;
        case (op_code)
          4'd1: begin m_olc = imm[5:0]; m_d = (m_olc == 0); end
          4'd2: begin m_olc = dl_val; m_d = (m_olc == 0); end
          4'd3: begin if (m_olc > 0) m_olc--; if (m_olc == 0) m_d = 1; end
          4'd4: begin m_ilc = imm[5:0]; m_inf = 0; end
          4'd5: m_inf = 1;
          4'd6: begin m_ilc = dl_val; m_inf = 0; end
          4'd7: begin
            na = mor(imm[5:0], m_a, m_b, m_c);
            nb = mor(imm[11:6], m_a, m_b, m_c);
            m_a = na; m_b = nb;
          end
          4'd8: begin
            if (dock_is_out && mv_dc) m_c = ship_c;
            else if (mv_ti || (mv_di && !dock_is_out)) m_c = sig_bit;
            m_ilc = 1; m_inf = 0;
          end
          default: ;
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input int op, input int p, input int im);
    op_code = op[3:0]; op_pred = p[2:0]; imm = im[11:0]; torpedo = 0;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset values
    chk("R1", "reset ilc", ilc_cnt, 1);
    chk("R1", "reset olc", olc_cnt, 0);
    chk("R1", "reset D", flag_d, 1);
    chk("R1", "reset ABC", {flag_a, flag_b, flag_c}, 0);
    chk("R1", "reset exec/err/inf", {exec_ok, pred_err, ilc_inf}, 0);

    // R4: load nonzero under predicate 101 (D=1), D clears
    drive(1, 5, 9);
    chk("R4", "olc load", olc_cnt, 9);
    chk("R4", "D cleared", flag_d, 0);
    // R2: predicate 101 now skipped, state unchanged
    drive(3, 5, 0);
    chk("R2", "skip exec", exec_ok, 0);
    chk("R2", "skip olc", olc_cnt, 9);
    // R10: torpedo sets D while olc nonzero, same-cycle op discarded
    op_code = 4'd3; op_pred = 3'd7; torpedo = 1;
    step();
    chk("R10", "torpedo D", flag_d, 1);
    chk("R10", "torpedo discards op", olc_cnt, 9);
    chk("R10", "torpedo exec", exec_ok, 0);
    torpedo = 0;
    // R5: decrement under D=1 with nonzero count leaves D set
    drive(3, 5, 0);
    chk("R5", "dec value", olc_cnt, 8);
    chk("R5", "D unchanged", flag_d, 1);
    // R4: load 1 from data latch then decrement to zero
    dl_val = 6'd1;
    drive(2, 7, 0);
    chk("R4", "dl load D", flag_d, 0);
    drive(3, 6, 0);
    chk("R5", "dec to zero D", flag_d, 1);
    drive(3, 7, 0);
    chk("R5", "saturate", olc_cnt, 0);
    // R6/R7: infinity then move
    drive(5, 7, 0);
    chk("R6", "inf set", ilc_inf, 1);
    mv_ti = 1; sig_bit = 1;
    drive(8, 7, 0);
    chk("R7", "move ilc", ilc_cnt, 1);
    chk("R8", "C from signal", flag_c, 1);
    mv_ti = 0; dock_is_out = 1; mv_dc = 1; ship_c = 0;
    drive(8, 7, 0);
    chk("R8", "C from ship", flag_c, 0);
    mv_dc = 0; mv_di = 1; sig_bit = 1;
    drive(8, 7, 0);
    chk("R8", "C held at output dock", flag_c, 0);
    mv_di = 0; dock_is_out = 0;
    // R9: A := A|~A = 1, B := 0 mask
    drive(7, 7, 12'b000000_110000);
    chk("R9", "A forced 1", flag_a, 1);
    chk("R9", "B zero mask", flag_b, 0);
    // R3: unused predicate
    drive(4, 4, 17);
    chk("R3", "code 100 skipped", ilc_cnt, 1);
    chk("R3", "error set", pred_err, 1);
    drive(0, 7, 0);
    chk("R3", "error sticky", pred_err, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      op_code = 4'($urandom_range(0, 9));
      op_pred = 3'($urandom_range(0, 7));
      imm = 12'($urandom);
      dl_val = ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom);
      if ($urandom_range(0, 5) == 0) imm[5:0] = 6'd0;
      {mv_dc, mv_ti, mv_di, dock_is_out, ship_c, sig_bit} = 6'($urandom);
      torpedo = ($urandom_range(0, 19) == 0);
      step();
    end
    done_run = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule